// File: doc/BRIEF.md
# ADC Conversion Clock Selector and Divider

This block produces the clock enable that paces an analog-to-digital conversion engine. All of its logic runs in the bus clock domain. A two-bit source field chooses the base rate: every bus cycle, every second bus cycle, rising edges of an alternate clock, or rising edges of an internal free-running converter oscillator. The alternate clock and the oscillator reach the block as enable levels from other domains. Each passes through a multi-flop synchronizer, and an edge detector turns it into a one-cycle event. A two-bit divide field then scales the chosen event stream by 1, 2, 4 or 8. The block emits a tick that is one bus cycle wide at the resulting rate.

Because the halved bus source can be combined with the largest divide, a fast bus can be brought down by a factor of 16. A low-power input shuts off every source except the internal oscillator. This lets conversions go on during wait or stop states when only that oscillator is selected. Whenever either control field changes, the divider restarts from zero. No tick with a shortened period is ever emitted. Two indicator outputs report the active source and whether it is currently delivering events.

Top module: `adc_clk_gen`

## Requirements
- R1: While `rst` is high, `tick` is low, `active_src` reads 00 and `src_on` is high. The reset setting is the bus source with a divide of 1, so with both control fields at 00 `tick` is high on every cycle after reset is released.
- R2: The source field `src_sel` is encoded 00 = bus clock, 01 = bus clock halved, 10 = alternate clock (rising edges of `alt_en`), 11 = internal oscillator (rising edges of `async_en`). `active_src` shows the setting in use one cycle after it is applied.
- R3: The divide field `div_sel` values 00, 01, 10 and 11 divide the selected source's event rate by 1, 2, 4 and 8.
- R4: With the halved bus source, events occur on every second bus cycle. Together with a divide field of 11 this gives one tick every 16 bus cycles.
- R5: While `lp_mode` is high, no tick is produced and `src_on` is low for sources 00, 01 and 10. With source 11 the ticks continue at their normal rate and `src_on` stays high.
- R6: Any change in `src_sel` or `div_sel` clears the divider. With the bus source and a divide of D, the first tick after a change is high exactly D cycles after the edge that captures the new setting, and it is never earlier.
- R7: `alt_en` and `async_en` pass through a two-flop synchronizer followed by an edge detector. With divide 1 and a matching source, `tick` rises at the third rising clock edge after the enable goes high.
- R8: `tick` is high for exactly one bus cycle whenever the overall division is greater than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source select field |
| div_sel | input | 2 | Post-divider field (log2 of divide) |
| alt_en | input | 1 | Alternate clock, as an asynchronous level |
| async_en | input | 1 | Internal oscillator, as an asynchronous level |
| lp_mode | input | 1 | Low-power state flag |
| tick | output | 1 | Conversion clock enable |
| active_src | output | 2 | Source setting in use |
| src_on | output | 1 | Selected source is not gated by low power |

## Verification
A table of settings drives all four sources under several divides. The test measures the spacing between successive ticks, and that spacing separates the bus, halved-bus, alternate (period 6) and oscillator (period 10) paths, as well as every divide step. Rows with the low-power flag set show that only the oscillator keeps running. Directed cases cover the rest: a divide change in the middle of a period, to expose a counter that is not cleared; a single alternate-enable edge, to pin down the synchronizer latency; and the reset state.

// File: rtl/adc_clk_pkg.sv
package adc_clk_pkg;

    localparam int DIV_FIELD_W = 2;
    localparam int MAX_DIV_LOG = (1 << DIV_FIELD_W) - 1;
    localparam int MAX_DIV     = 1 << MAX_DIV_LOG;
    localparam int CNT_W       = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        SRC_BUS      = 2'b00,
        SRC_BUS_HALF = 2'b01,
        SRC_ALT      = 2'b10,
        SRC_ASYNC    = 2'b11
    } clk_src_e;

    typedef struct packed {
        clk_src_e                src;
        logic [DIV_FIELD_W-1:0]  div;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{src: SRC_BUS, div: '0};

    // Source is silenced in low power unless it is the internal oscillator.
    function automatic logic src_gated(input clk_src_e s, input logic lp);
        return lp && (s != SRC_ASYNC);
    endfunction

    // Terminal count of the post-divider for a divide field value.
    function automatic logic [CNT_W-1:0] div_limit(input logic [DIV_FIELD_W-1:0] d);
        logic [CNT_W:0] one_sh;
        one_sh = (CNT_W+1)'(1) << d;
        return CNT_W'(one_sh - 1'b1);
    endfunction

endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/adc_src_mux.sv
module adc_src_mux
    import adc_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  clk_src_e src,
    input  logic     lp_mode,
    input  logic     alt_rise,
    input  logic     osc_rise,
    output logic     evt,
    output logic     src_on
);
    logic half_q;
    logic raw_evt;

    always_ff @(posedge clk) begin
        if (rst || restart) half_q <= 1'b0;
        else                half_q <= ~half_q;
    end

    always_comb begin
        unique case (src)
            SRC_BUS:      raw_evt = 1'b1;
            SRC_BUS_HALF: raw_evt = half_q;
            SRC_ALT:      raw_evt = alt_rise;
            SRC_ASYNC:    raw_evt = osc_rise;
            default:      raw_evt = 1'b0;
        endcase
    end

    assign src_on = ~src_gated(src, lp_mode);
    assign evt    = raw_evt & src_on;

    // R4: halved bus source never produces events on back-to-back cycles
    assert_half_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_BUS_HALF && evt && !restart) |=> !evt);

endmodule

// File: rtl/adc_post_div.sv
module adc_post_div
    import adc_clk_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   restart,
    input  logic                   evt,
    input  logic [DIV_FIELD_W-1:0] div,
    output logic                   tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             tick_q;

    assign limit = div_limit(div);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (evt) begin
            if (cnt_q == limit) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R8: a tick lasts one cycle whenever the divider is not a pass-through
    assert_tick_width_R8: assert property (@(posedge clk) disable iff (rst)
        (tick_q && limit != '0) |=> !tick_q);

endmodule

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
    import adc_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             src_sel,
    input  logic [DIV_FIELD_W-1:0] div_sel,
    input  logic                   alt_en,
    input  logic                   async_en,
    input  logic                   lp_mode,
    output logic                   tick,
    output logic [1:0]             active_src,
    output logic                   src_on
);
    clk_cfg_t cfg_in, cfg_q;
    logic     restart;
    logic     alt_rise, osc_rise, evt;

    assign cfg_in  = '{src: clk_src_e'(src_sel), div: div_sel};
    assign restart = (cfg_in != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_in;
    end

    adc_sync_edge #(.STAGES(SYNC_STAGES)) u_alt_sync (
        .clk(clk), .rst(rst), .d_async(alt_en), .rise(alt_rise)
    );

    adc_sync_edge #(.STAGES(SYNC_STAGES)) u_osc_sync (
        .clk(clk), .rst(rst), .d_async(async_en), .rise(osc_rise)
    );

    adc_src_mux u_mux (
        .clk(clk), .rst(rst), .restart(restart), .src(cfg_q.src),
        .lp_mode(lp_mode), .alt_rise(alt_rise), .osc_rise(osc_rise),
        .evt(evt), .src_on(src_on)
    );

    adc_post_div u_div (
        .clk(clk), .rst(rst), .restart(restart), .evt(evt),
        .div(cfg_q.div), .tick(tick)
    );

    assign active_src = cfg_q.src;

    // R1: reset parks the block on the bus source with no tick
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!tick && active_src == 2'b00));

    // R6: a setting change never lets a tick out on the following cycle
    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

    // R5: a gated source produces no tick
    assert_lp_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (lp_mode && cfg_q.src != SRC_ASYNC) |=> !tick);

endmodule

// File: tb/tb_adc_clk_gen.sv
module tb_adc_clk_gen;

    localparam int ALT_HALF = 3;   // alternate period 6 cycles
    localparam int OSC_HALF = 5;   // oscillator period 10 cycles
    localparam int WAIT_MAX = 300;

    typedef struct packed {
        logic [1:0] src;
        logic [1:0] div;
        logic       lp;
        logic [7:0] period;   // 0: no tick expected
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 2'b00, 1'b0, 8'd1},
        '{2'b00, 2'b01, 1'b0, 8'd2},
        '{2'b00, 2'b10, 1'b0, 8'd4},
        '{2'b00, 2'b11, 1'b0, 8'd8},
        '{2'b01, 2'b00, 1'b0, 8'd2},
        '{2'b01, 2'b11, 1'b0, 8'd16},
        '{2'b10, 2'b00, 1'b0, 8'd6},
        '{2'b10, 2'b01, 1'b0, 8'd12},
        '{2'b11, 2'b00, 1'b0, 8'd10},
        '{2'b11, 2'b10, 1'b0, 8'd40},
        '{2'b11, 2'b01, 1'b1, 8'd20},
        '{2'b10, 2'b00, 1'b1, 8'd0},
        '{2'b00, 2'b01, 1'b1, 8'd0},
        '{2'b01, 2'b10, 1'b1, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'b00;
    logic [1:0] div_sel = 2'b00;
    logic       lp_mode = 1'b0;
    logic       alt_run = 1'b1;
    logic       alt_man = 1'b0;
    logic       alt_gen = 1'b0;
    logic       osc_gen = 1'b0;
    logic       alt_en;
    logic       tick;
    logic [1:0] active_src;
    logic       src_on;
    int         a_ph = 0;
    int         o_ph = 0;
    int         n_checks = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    assign alt_en = alt_run ? alt_gen : alt_man;

    always @(negedge clk) begin
        if (a_ph == ALT_HALF - 1) begin a_ph <= 0; alt_gen <= ~alt_gen; end
        else a_ph <= a_ph + 1;
        if (o_ph == OSC_HALF - 1) begin o_ph <= 0; osc_gen <= ~osc_gen; end
        else o_ph <= o_ph + 1;
    end

    adc_clk_gen dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .div_sel(div_sel),
        .alt_en(alt_en), .async_en(osc_gen), .lp_mode(lp_mode),
        .tick(tick), .active_src(active_src), .src_on(src_on)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // interval between two consecutive ticks, 0 if none seen
    task automatic measure(output int gap, output int width_ok);
        int n;
        n = 0;
        gap = 0;
        width_ok = 1;
        while (!tick && n < WAIT_MAX) begin @(negedge clk); n++; end
        if (!tick) return;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 1 && tick) width_ok = 0;
        end while (!tick && n < WAIT_MAX);
        gap = tick ? n : 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int gap, wok, cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick in reset", tick, 0);
        check("R1 active_src in reset", active_src, 0);
        check("R1 src_on in reset", src_on, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 default divide-by-1 first", tick, 1);
        @(negedge clk);
        check("R1 default divide-by-1 second", tick, 1);

        // table walk: R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            src_sel = VECS[i].src;
            div_sel = VECS[i].div;
            lp_mode = VECS[i].lp;
            repeat (60) @(negedge clk);
            check("R2 active_src", active_src, int'(VECS[i].src));
            check("R5 src_on", src_on,
                  int'(!(VECS[i].lp && VECS[i].src != 2'b11)));
            if (VECS[i].period == 0) begin
                cnt = 0;
                for (int k = 0; k < 200; k++) begin
                    @(negedge clk);
                    if (tick) cnt++;
                end
                check("R5 gated source ticks", cnt, 0);
            end else begin
                measure(gap, wok);
                check("R3 R4 tick period", gap, int'(VECS[i].period));
                if (VECS[i].period > 1)
                    check("R8 single-cycle tick", wok, 1);
            end
        end
        lp_mode = 1'b0;

        // R6: divide change mid-period restarts the count
        src_sel = 2'b00;
        div_sel = 2'b11;
        repeat (30) @(negedge clk);
        while (!tick) @(negedge clk);
        repeat (3) @(negedge clk);
        div_sel = 2'b01;
        @(negedge clk);
        check("R6 no tick edge 1 after change", tick, 0);
        @(negedge clk);
        check("R6 no tick edge 2 after change", tick, 0);
        @(negedge clk);
        check("R6 first tick after change", tick, 1);
        @(negedge clk);
        check("R6 tick drops", tick, 0);

        // R6: change from div 2 to div 8 right after a tick
        while (!tick) @(negedge clk);
        div_sel = 2'b11;
        cnt = 0;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (tick && cnt == 0) cnt = k;
        end
        check("R6 first tick edge after div8 change", cnt, 9);

        // R7: synchronizer latency on the alternate enable
        alt_run = 1'b0;
        alt_man = 1'b0;
        src_sel = 2'b10;
        div_sel = 2'b00;
        repeat (10) @(negedge clk);
        check("R7 idle alt no tick", tick, 0);
        alt_man = 1'b1;
        @(negedge clk);
        check("R7 edge1 no tick", tick, 0);
        @(negedge clk);
        check("R7 edge2 no tick", tick, 0);
        @(negedge clk);
        check("R7 edge3 tick", tick, 1);
        @(negedge clk);
        check("R7 R8 single event single tick", tick, 0);
        repeat (10) @(negedge clk);
        check("R7 level held no extra tick", tick, 0);

        report();
        $finish;
    end

endmodule